// File: doc/BRIEF.md
# Serial Flash Array Read Sequencer

This block is the read side of a serial flash memory seen from its SPI bus. A host pulls chip select low, clocks in an 8-bit read command, a 24-bit address and a 32-bit filler field, and then keeps clocking to receive array bytes on the serial output, most significant bit first. The block holds the array as an internal synthesizable RAM of a configurable number of pages, each 264 bytes long. The RAM has a byte-wide fill port so that its contents can be put in place before reading.

Two read commands are decoded. The streaming read walks through the whole array. When it reaches the end of a page it goes on at byte 0 of the next page, and after the last page it goes back to page 0. The looping read stays inside the addressed page and returns to byte 0 of that page after its last byte. Raising chip select ends any command and releases the output. The SPI lines are sampled with the block's own clock, so SCK must be slow compared with that clock.

Top module: `arrd_seq`

## Requirements
- R1: Opcode 0x68 or 0xE8 starts a streaming read. The first output byte is the one at the addressed page and byte, and each byte is sent bit 7 first.
- R2: Opcode 0x52 or 0xD2 starts a looping read that returns the addressed bytes in order.
- R3: Of the 24 address bits, bits 23..21 are ignored, bits 20..9 give the page and bits 8..0 give the byte. A page number at or above the page count is reduced modulo the page count.
- R4: The output enable stays low while the opcode, the address and the 32 filler bits are shifted in. The first data bit is driven on the falling SCK edge that follows the 64th rising edge.
- R5: In a streaming read, byte 263 of a page is followed without a gap by byte 0 of the next page.
- R6: In a streaming read, byte 263 of the last page is followed by byte 0 of page 0.
- R7: In a looping read, byte 263 is followed by byte 0 of the same page.
- R8: Within 4 clock cycles of chip select going high, the output enable drops. A new command can then start, even after a read that was cut off in the middle of a byte.
- R9: Any other opcode leaves the output enable low until chip select rises.
- R10: A byte address from 264 to 511 is reduced modulo 264.
- R11: Inputs are sampled on the rising SCK edge and the output changes only after a falling edge, whether SCK idles low or high.
- R12: During and right after reset the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; it oversamples the SPI lines |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, valid while miso_oe is high |
| miso_oe | output | 1 | Output enable for miso; low means high impedance |
| fill_en | input | 1 | Write strobe of the array fill port |
| fill_addr | input | AW | Flat byte address for the fill (page*264+byte) |
| fill_data | input | 8 | Byte to be written into the array |

## Verification
The bench builds the block with 3 pages of 264 bytes. The page count is not a power of two, so reducing a large page number is a real modulo and not a dropped bit. The end of the array is also only one page crossing away, which lets a short read pass through both the page-to-page crossing and the wrap from the last page to page 0. Both SCK idle levels, all four opcodes, reserved address bits that are set, out-of-range byte addresses, a read cut off in mid-byte and an unknown opcode are all driven against a behavioural model of the array.

// File: rtl/arrd_pkg.sv
// Shared constants and types for the array read sequencer.
// Assumes: command format of 8 opcode bits, 24 address bits, 32 filler bits.
package arrd_pkg;

    localparam int PAGE_BYTES_DEF = 264;
    localparam int HDR_BITS       = 64;
    localparam int ADDR_END_BIT   = 31;

    localparam logic [7:0] OPC_STREAM_A = 8'h68;
    localparam logic [7:0] OPC_STREAM_B = 8'hE8;
    localparam logic [7:0] OPC_LOOP_A   = 8'h52;
    localparam logic [7:0] OPC_LOOP_B   = 8'hD2;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_ADDR,
        ST_FILL,
        ST_DATA,
        ST_DROP
    } rd_state_e;

endpackage

// File: rtl/arrd_sync.sv
// Two-stage synchroniser for a bundle of asynchronous single-bit inputs.
// Assumes: each lane is slow compared with clk; RST_VAL gives the idle level.
module arrd_sync #(
    parameter int             W       = 3,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg1_q;
    logic [W-1:0] stg2_q;

    // Move the asynchronous inputs through two flops into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg1_q <= RST_VAL;
            stg2_q <= RST_VAL;
        end else begin
            stg1_q <= din;
            stg2_q <= stg1_q;
        end
    end

    assign dout = stg2_q;

endmodule

// File: rtl/arrd_mem.sv
// Byte-wide array storage with one write port (fill) and one registered read port.
// Assumes: the read address is always below DEPTH; contents are not reset.
module arrd_mem #(
    parameter int DEPTH = 2112,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0] cells [DEPTH];

    // Write from the fill port and keep the read data one cycle behind the address.
    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < DEPTH)) begin
            cells[wr_addr] <= wr_data;
        end
        rd_data <= cells[rd_addr];
    end

endmodule

// File: rtl/arrd_ptr.sv
// Read pointer: loads page/byte from a command, reduces both into range and
// advances one byte per step, with whole-array or single-page wrapping.
// Assumes: load and adv are single-cycle pulses and never coincide.
module arrd_ptr #(
    parameter int PAGES      = 8,
    parameter int PAGE_BYTES = 264,
    parameter int AW         = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [11:0]   ld_page,
    input  logic [8:0]    ld_byte,
    input  logic          adv,
    input  logic          wrap_all,
    output logic [AW-1:0] flat
);

    localparam int PW = (PAGES > 1) ? $clog2(PAGES) : 1;
    localparam logic [8:0]    BYTE_LAST = 9'(PAGE_BYTES - 1);
    localparam logic [8:0]    BYTE_SPAN = 9'(PAGE_BYTES);
    localparam logic [PW-1:0] PAGE_LAST = PW'(PAGES - 1);

    logic [PW-1:0] pg_q;
    logic [8:0]    by_q;

    // Hold the current page and byte; load from a command or step forward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_q <= '0;
            by_q <= '0;
        end else if (load) begin
            pg_q <= PW'(32'(ld_page) % PAGES);
            by_q <= (ld_byte >= BYTE_SPAN) ? (ld_byte - BYTE_SPAN) : ld_byte;
        end else if (adv) begin
            if (by_q == BYTE_LAST) begin
                by_q <= '0;
                if (wrap_all) begin
                    pg_q <= (pg_q == PAGE_LAST) ? '0 : pg_q + PW'(1);
                end
            end else begin
                by_q <= by_q + 9'd1;
            end
        end
    end

    // Form the flat array address from page and byte.
    always_comb begin
        flat = AW'(pg_q) * AW'(PAGE_BYTES) + AW'(by_q);
    end

endmodule

// File: rtl/arrd_seq.sv
// SPI-side read sequencer: decodes the command header (opcode, address,
// filler) sampled on rising SCK and shifts array bytes out on falling SCK.
// Assumes: clk is at least several times faster than SCK; miso is only
// meaningful while miso_oe is high (the pad buffer is outside this block).
module arrd_seq
    import arrd_pkg::*;
#(
    parameter  int PAGES      = 8,
    parameter  int PAGE_BYTES = PAGE_BYTES_DEF,
    localparam int DEPTH      = PAGES * PAGE_BYTES,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sck,
    input  logic          mosi,
    output logic          miso,
    output logic          miso_oe,
    input  logic          fill_en,
    input  logic [AW-1:0] fill_addr,
    input  logic [7:0]    fill_data
);

    logic [2:0]    sync_v;
    logic          cs_act;
    logic          sck_s;
    logic          sck_d;
    logic          mosi_s;
    logic          sck_rise;
    logic          sck_fall;

    rd_state_e     state_q;
    logic [5:0]    cnt_q;
    logic [19:0]   sh_q;
    logic [20:0]   hdr;
    logic          wrap_all_q;
    logic          is_stream;
    logic          is_loop;
    logic          ptr_load;
    logic          ptr_adv;

    logic [2:0]    obit_q;
    logic [6:0]    osr_q;
    logic          miso_q;
    logic          oe_q;

    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;

    arrd_sync #(
        .W       (3),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cs_n, sck, mosi}),
        .dout  (sync_v)
    );

    assign cs_act = ~sync_v[2];
    assign sck_s  = sync_v[1];
    assign mosi_s = sync_v[0];

    // Remember the previous synchronised SCK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
        end else begin
            sck_d <= sck_s;
        end
    end

    // Decode SCK edges and the command fields as the header arrives.
    always_comb begin
        sck_rise  = cs_act &  sck_s & ~sck_d;
        sck_fall  = cs_act & ~sck_s &  sck_d;
        hdr       = {sh_q, mosi_s};
        is_stream = (hdr[7:0] == OPC_STREAM_A) || (hdr[7:0] == OPC_STREAM_B);
        is_loop   = (hdr[7:0] == OPC_LOOP_A)   || (hdr[7:0] == OPC_LOOP_B);
        ptr_load  = sck_rise && (state_q == ST_ADDR) && (cnt_q == 6'(ADDR_END_BIT));
        ptr_adv   = sck_fall && (state_q == ST_DATA) && (obit_q == 3'd0);
    end

    // Header sequencer: count rising edges, decode the opcode, step the phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_OPC;
            cnt_q      <= '0;
            sh_q       <= '0;
            wrap_all_q <= 1'b0;
        end else if (!cs_act) begin
            state_q <= ST_OPC;
            cnt_q   <= '0;
        end else if (sck_rise) begin
            sh_q  <= hdr[19:0];
            cnt_q <= cnt_q + 6'd1;
            case (state_q)
                ST_OPC: begin
                    if (cnt_q == 6'd7) begin
                        state_q    <= (is_stream || is_loop) ? ST_ADDR : ST_DROP;
                        wrap_all_q <= is_stream;
                    end
                end
                ST_ADDR: begin
                    if (cnt_q == 6'(ADDR_END_BIT)) begin
                        state_q <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (cnt_q == 6'(HDR_BITS - 1)) begin
                        state_q <= ST_DATA;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Output shifter: on each falling edge in the data phase drive the next bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            obit_q <= '0;
            osr_q  <= '0;
            miso_q <= 1'b0;
            oe_q   <= 1'b0;
        end else if (!cs_act) begin
            obit_q <= '0;
            oe_q   <= 1'b0;
        end else if (sck_fall && (state_q == ST_DATA)) begin
            oe_q   <= 1'b1;
            obit_q <= obit_q + 3'd1;
            if (obit_q == 3'd0) begin
                miso_q <= rd_data[7];
                osr_q  <= rd_data[6:0];
            end else begin
                miso_q <= osr_q[6];
                osr_q  <= {osr_q[5:0], 1'b0};
            end
        end
    end

    arrd_ptr #(
        .PAGES      (PAGES),
        .PAGE_BYTES (PAGE_BYTES),
        .AW         (AW)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .ld_page  (hdr[20:9]),
        .ld_byte  (hdr[8:0]),
        .adv      (ptr_adv),
        .wrap_all (wrap_all_q),
        .flat     (rd_addr)
    );

    arrd_mem #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_mem (
        .clk     (clk),
        .wr_en   (fill_en),
        .wr_addr (fill_addr),
        .wr_data (fill_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign miso    = miso_q;
    assign miso_oe = oe_q;

endmodule

// File: rtl/arrd_seq_chk.sv
// Property checker for arrd_seq, attached through bind.
// Assumes: signals come from the bound instance's scope.
module arrd_seq_chk
    import arrd_pkg::*;
#(
    parameter int DEPTH = 2112,
    parameter int AW    = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          cs_act,
    input logic          sck_rise,
    input logic          sck_fall,
    input logic          miso,
    input logic          miso_oe,
    input rd_state_e     state_q,
    input logic [AW-1:0] rd_addr
);

    logic [2:0] hi_cnt_q;
    logic [6:0] rise_cnt_q;

    // Count consecutive cycles with the chip-select port high (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_n) begin
            hi_cnt_q <= '0;
        end else if (hi_cnt_q != 3'd7) begin
            hi_cnt_q <= hi_cnt_q + 3'd1;
        end
    end

    // Count rising SCK edges seen since chip select became active (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            rise_cnt_q <= '0;
        end else if (sck_rise && (rise_cnt_q != 7'd127)) begin
            rise_cnt_q <= rise_cnt_q + 7'd1;
        end
    end

    assert_reset_quiet_R12: assert property (@(posedge clk)
        !rst_n |=> !miso_oe);

    assert_cs_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt_q >= 3'd4) |-> !miso_oe);

    assert_late_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miso_oe) |-> (rise_cnt_q == 7'd64));

    assert_fall_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe && $past(miso_oe) && !$stable(miso)) |-> $past(sck_fall));

    assert_drop_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DROP) |-> !miso_oe);

    assert_ptr_bounds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_addr) < DEPTH);

endmodule

bind arrd_seq arrd_seq_chk #(
    .DEPTH (DEPTH),
    .AW    (AW)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .cs_act   (cs_act),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .miso     (miso),
    .miso_oe  (miso_oe),
    .state_q  (state_q),
    .rd_addr  (rd_addr)
);

// File: tb/test_arrd_seq.sv
// Bench for arrd_seq: drives SPI commands and compares every returned byte
// with a behavioural array model.
module test_arrd_seq;

    localparam int PAGES = 3;
    localparam int PB    = 264;
    localparam int DEPTH = PAGES * PB;
    localparam int AW    = $clog2(DEPTH);
    localparam int HALF  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          sck = 1'b0;
    logic          mosi = 1'b0;
    logic          miso;
    logic          miso_oe;
    logic          fill_en = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic [7:0]    fill_data = '0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    arrd_seq #(.PAGES(PAGES)) i_arrd_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sck       (sck),
        .mosi      (mosi),
        .miso      (miso),
        .miso_oe   (miso_oe),
        .fill_en   (fill_en),
        .fill_addr (fill_addr),
        .fill_data (fill_data)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 29) + ((a / 256) * 101) + 5);
    endfunction

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // One command: header, nbytes data bytes, extra bits, then release.
    task automatic run_cmd(logic [7:0] op, logic [23:0] addr, int nbytes,
                           int extra, bit idle_hi, string tag);
        logic [63:0] bits;
        bit          known;
        bit          cont;
        bit          hdr_quiet;
        bit          oe_seen;
        int          pg;
        int          by;
        logic [7:0]  got;
        bits  = {op, addr, 32'hC3A5_5A3C};
        cont  = (op == 8'h68) || (op == 8'hE8);
        known = cont || (op == 8'h52) || (op == 8'hD2);
        pg    = int'(addr[20:9]) % PAGES;
        by    = int'(addr[8:0]) % PB;
        sck   = idle_hi;
        wait_n(6);
        cs_n = 1'b0;
        wait_n(4);
        hdr_quiet = 1'b1;
        for (int i = 63; i >= 0; i--) begin
            sck  = 1'b0;
            mosi = bits[i];
            wait_n(HALF);
            if (miso_oe) hdr_quiet = 1'b0;
            sck = 1'b1;
            wait_n(HALF);
        end
        check({tag, " R4 header quiet"}, int'(hdr_quiet), 1);
        oe_seen = 1'b0;
        for (int b = 0; b < nbytes; b++) begin
            got = '0;
            for (int k = 0; k < 8; k++) begin
                sck  = 1'b0;
                mosi = 1'b0;
                wait_n(HALF);
                got = {got[6:0], miso};
                if (miso_oe) oe_seen = 1'b1;
                sck = 1'b1;
                wait_n(HALF);
            end
            if (known) begin
                check(tag, int'(got), int'(pat(pg * PB + by)));
                by++;
                if (by == PB) begin
                    by = 0;
                    if (cont) pg = (pg + 1) % PAGES;
                end
            end
        end
        for (int k = 0; k < extra; k++) begin
            sck = 1'b0;
            wait_n(HALF);
            sck = 1'b1;
            wait_n(HALF);
        end
        if (!known) check({tag, " R9 no drive"}, int'(oe_seen), 0);
        if (!idle_hi) sck = 1'b0;
        wait_n(2);
        cs_n = 1'b1;
        wait_n(5);
        check({tag, " R8 released"}, int'(miso_oe), 0);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        wait_n(4);
        check("R12 reset oe", int'(miso_oe), 0);
        rst_n = 1'b1;
        wait_n(2);
        check("R12 after reset oe", int'(miso_oe), 0);
        for (int a = 0; a < DEPTH; a++) begin
            fill_en   = 1'b1;
            fill_addr = AW'(a);
            fill_data = pat(a);
            wait_n(1);
        end
        fill_en = 1'b0;
        wait_n(4);

        // R1 streaming read, SCK idle low (R11)
        run_cmd(8'h68, {3'b000, 12'd1, 9'd5}, 6, 0, 1'b0, "R1 stream idle-low R11");
        // R1 streaming read via second opcode, SCK idle high (R11), page crossing (R5)
        run_cmd(8'hE8, {3'b000, 12'd0, 9'd259}, 10, 0, 1'b1, "R5 page crossing R11");
        // R6 last page wraps to page 0
        run_cmd(8'h68, {3'b000, 12'd2, 9'd261}, 8, 0, 1'b0, "R6 array wrap");
        // R2 / R7 looping read wraps inside the page
        run_cmd(8'h52, {3'b000, 12'd1, 9'd260}, 9, 0, 1'b0, "R7 page loop");
        // R2 second opcode, idle high
        run_cmd(8'hD2, {3'b000, 12'd2, 9'd0}, 5, 0, 1'b1, "R2 loop read");
        // R3 reserved bits set, page 4 reduces to page 1
        run_cmd(8'h68, {3'b111, 12'd4, 9'd17}, 4, 0, 1'b0, "R3 reserved and page modulo");
        // R10 byte address 300 reduces to 36
        run_cmd(8'h52, {3'b000, 12'd0, 9'd300}, 4, 0, 1'b0, "R10 byte modulo");
        // R10 byte address 511 reduces to 247 in a streaming read
        run_cmd(8'hE8, {3'b000, 12'd2, 9'd511}, 3, 0, 1'b1, "R10 byte 511");
        // R8 read cut off mid-byte, then a fresh command
        run_cmd(8'h68, {3'b000, 12'd1, 9'd100}, 2, 3, 1'b0, "R8 cut off");
        run_cmd(8'h52, {3'b000, 12'd0, 9'd0}, 3, 0, 1'b0, "R8 next command");
        // R9 unrecognised opcode
        run_cmd(8'h0B, {3'b000, 12'd0, 9'd0}, 3, 0, 1'b0, "R9 unknown opcode");
        run_cmd(8'hE8, {3'b000, 12'd1, 9'd263}, 3, 0, 1'b1, "R5 after drop");

        done = 1'b1;
        report();
    end

endmodule